// File: doc/BRIEF.md
# Bus-Search Branch Step Sequencer

This block runs one branch step of a single-wire bus device-identity search as a single hardware sequence. On a start strobe it asks the bus master for two single-bit reads, the identity bit and then its complement, and decides which way the search branches. Unless both bits came back as 1, it asks for a single-bit write of the chosen direction. It then reports a 3-bit result code with a one-cycle done pulse. The caller supplies the preferred direction, which is used only when the devices on the bus disagree. The outer search loop, discrepancy bookkeeping and CRC checks belong to the caller.

The block talks to a bit-level bus master. Requests leave on a valid/ready channel. `req_valid` rises with `req_wr` and `req_bit` set, and all three hold steady until a cycle in which `req_ready` is high. That cycle is the handshake, and the master may stall for as long as it needs. The completion channel has no back-pressure. After a handshake the block waits for either `cpl_valid` (with `cpl_data`) or `cpl_tmo`, and it ignores that channel at all other times. A timeout aborts the step.

Top module: `owsrch_triplet`

## Requirements
- R1: After an accepted start, the block issues in order a read request (`req_wr`=0) for the identity bit, a read request (`req_wr`=0) for the complement bit, and then, when a write is due, a write request (`req_wr`=1). It issues a new request only after the previous one has completed.
- R2: If both received bits are 1, the result is 3'b011, no write request is issued, and `err` is 0.
- R3: If both received bits are 0, the direction is the `pref_dir` value sampled with the accepted start, and that value is written as `req_bit`. The result is 3'b100 when the direction is 1 and 3'b000 when it is 0.
- R4: If exactly one received bit is 1, the direction equals the identity bit and is written as `req_bit`. The result is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R5: Only bit 0 of `cpl_data` is used. The upper bits have no effect on the result or on the written direction.
- R6: `cpl_tmo` seen while a completion is awaited aborts the step. `done` pulses, `err` is 1, the result is 3'b011, and no further request is issued. When `cpl_tmo` and `cpl_valid` arrive in the same cycle, the timeout wins.
- R7: `done` is high for exactly one cycle per step, in the cycle after the last completion or timeout. `busy` is low in that cycle and high from the cycle after the accepted start until then. `result` and `err` hold their values until the next `done`.
- R8: A start strobe that arrives while `busy` is high is ignored and causes no extra request or step.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_wr` and `req_bit` stay unchanged. A completion or timeout that arrives when no completion is awaited is ignored.
- R10: After reset, `busy`, `done`, `err`, `req_valid` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that begins one step while idle |
| pref_dir | input | 1 | Preferred direction, sampled with start |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle pulse when a step ends |
| err | output | 1 | Last step aborted by timeout |
| result | output | 3 | Code: bit0 identity bit, bit1 complement bit, bit2 direction taken |
| req_valid | output | 1 | Bit request valid |
| req_ready | input | 1 | Bus master accepts the request |
| req_wr | output | 1 | 1 = write request, 0 = read request |
| req_bit | output | 1 | Bit to write (0 for reads) |
| cpl_valid | input | 1 | Sub-transfer completed |
| cpl_data | input | DW | Received value; only bit 0 is used |
| cpl_tmo | input | 1 | Sub-transfer timed out |

## Verification
Completion and timeout can reach the block in the same cycle on any of the three sub-transfers. The bench provokes this by raising `cpl_valid` and `cpl_tmo` together, on both read phases and on the write phase. It counts the step correct only if `done` shows the abort code with `err` set and no later request appears. A second collision is a start strobe that arrives while a completion is still awaited. The bench judges it by the absence of any extra request and of any second `done` pulse.

// File: rtl/owt_pkg.sv
package owt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDBIT = 2'd0,
    PH_CPBIT = 2'd1,
    PH_WRDIR = 2'd2
  } seq_phase_e;

  localparam logic [2:0] CODE_NODEV = 3'b011;

  typedef struct packed {
    logic       dir;
    logic       write;
    logic [2:0] code;
  } branch_t;

endpackage

// File: rtl/owt_decide.sv
module owt_decide
  import owt_pkg::*;
(
  input  logic    id_bit,
  input  logic    cp_bit,
  input  logic    pref,
  output branch_t br
);

  always_comb begin
    br.write = !(id_bit && cp_bit);
    if (id_bit == cp_bit) br.dir = id_bit ? 1'b0 : pref;
    else                  br.dir = id_bit;
    br.code = {br.dir, cp_bit, id_bit};
  end

endmodule

// File: rtl/owt_ctrl.sv
module owt_ctrl
  import owt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pref_dir,
  output logic          busy,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_wr,
  output logic          req_bit,
  input  logic          cpl_valid,
  input  logic [DW-1:0] cpl_data,
  input  logic          cpl_tmo,
  output logic          fin,
  output logic          fin_abort,
  output logic [2:0]    fin_code
);

  seq_state_e st_q;
  seq_phase_e ph_q;
  logic       pref_q, id_q, cp_q, dir_q;
  logic       rx_bit, cp_in;
  branch_t    br;

  assign rx_bit = cpl_data[0];

  generate
    if (DW > 1) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^cpl_data[DW-1:1];
    end
  endgenerate

  assign cp_in = (ph_q == PH_CPBIT) ? rx_bit : cp_q;

  owt_decide u_decide (
    .id_bit (id_q),
    .cp_bit (cp_in),
    .pref   (pref_q),
    .br     (br)
  );

  logic waiting;
  assign waiting   = (st_q == ST_WAIT);
  assign busy      = (st_q != ST_IDLE);
  assign req_valid = (st_q == ST_ISSUE);
  assign req_wr    = (ph_q == PH_WRDIR);
  assign req_bit   = (ph_q == PH_WRDIR) ? dir_q : 1'b0;

  assign fin_abort = waiting && cpl_tmo;
  assign fin = waiting && (cpl_tmo || (cpl_valid &&
               ((ph_q == PH_WRDIR) || ((ph_q == PH_CPBIT) && !br.write))));
  assign fin_code = fin_abort ? CODE_NODEV : br.code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_IDBIT;
      pref_q <= 1'b0;
      id_q   <= 1'b0;
      cp_q   <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_ISSUE;
            ph_q   <= PH_IDBIT;
            pref_q <= pref_dir;
          end
        end
        ST_ISSUE: begin
          if (req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cpl_tmo) begin
            st_q <= ST_IDLE;
            ph_q <= PH_IDBIT;
          end else if (cpl_valid) begin
            unique case (ph_q)
              PH_IDBIT: begin
                id_q <= rx_bit;
                ph_q <= PH_CPBIT;
                st_q <= ST_ISSUE;
              end
              PH_CPBIT: begin
                cp_q  <= rx_bit;
                dir_q <= br.dir;
                if (br.write) begin
                  ph_q <= PH_WRDIR;
                  st_q <= ST_ISSUE;
                end else begin
                  ph_q <= PH_IDBIT;
                  st_q <= ST_IDLE;
                end
              end
              default: begin
                ph_q <= PH_IDBIT;
                st_q <= ST_IDLE;
              end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: request fields stay put under back-pressure
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_wr) && $stable(req_bit)));

  // R2: no write is requested after both bits read as 1
  p_no_wr_nodev_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_wr) |-> !(id_q && cp_q));

  // R8: a start while busy does not restart the sequence
  p_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && req_valid && !req_ready) |=> (req_valid && $stable(req_wr)));

endmodule

// File: rtl/owt_result.sv
module owt_result
  import owt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fin,
  input  logic       fin_abort,
  input  logic [2:0] fin_code,
  output logic       done,
  output logic       err,
  output logic [2:0] result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      err    <= 1'b0;
      result <= 3'b000;
    end else begin
      done <= fin;
      if (fin) begin
        err    <= fin_abort;
        result <= fin_code;
      end
    end
  end

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: an aborted step reports the no-device code
  p_abort_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == CODE_NODEV));

  // R7: result and error flag hold between steps
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fin) |-> ($stable(result) && $stable(err)));

endmodule

// File: rtl/owsrch_triplet.sv
module owsrch_triplet
  import owt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pref_dir,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [2:0]    result,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_wr,
  output logic          req_bit,
  input  logic          cpl_valid,
  input  logic [DW-1:0] cpl_data,
  input  logic          cpl_tmo
);

  logic       fin, fin_abort;
  logic [2:0] fin_code;

  owt_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pref_dir  (pref_dir),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_wr    (req_wr),
    .req_bit   (req_bit),
    .cpl_valid (cpl_valid),
    .cpl_data  (cpl_data),
    .cpl_tmo   (cpl_tmo),
    .fin       (fin),
    .fin_abort (fin_abort),
    .fin_code  (fin_code)
  );

  owt_result u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin       (fin),
    .fin_abort (fin_abort),
    .fin_code  (fin_code),
    .done      (done),
    .err       (err),
    .result    (result)
  );

  // R7: busy is low whenever done is reported
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/owsrch_triplet_test.sv
module owsrch_triplet_test;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, pref_dir = 1'b0;
  logic          busy, done, err;
  logic [2:0]    result;
  logic          req_valid, req_wr, req_bit;
  logic          req_ready = 1'b0;
  logic          cpl_valid = 1'b0, cpl_tmo = 1'b0;
  logic [DW-1:0] cpl_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  owsrch_triplet #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
    .busy(busy), .done(done), .err(err), .result(result),
    .req_valid(req_valid), .req_ready(req_ready), .req_wr(req_wr),
    .req_bit(req_bit), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .cpl_tmo(cpl_tmo)
  );

  function automatic logic [2:0] exp_code(bit pref, bit idb, bit cpb);
    bit d;
    if (idb && cpb) return 3'b011;
    d = (idb == cpb) ? pref : idb;
    return {d, cpb, idb};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one full step; tmo_at = sub-transfer index that times out (>=3: none)
  task automatic step(input bit pref, input bit idb, input bit cpb,
                      input int tmo_at, input bit both, input bit poke);
    bit nodev = idb && cpb;
    int nsub = nodev ? 2 : 3;
    int last = (tmo_at < nsub) ? tmo_at : nsub - 1;
    bit abort = (tmo_at < nsub);
    bit wbit = (idb == cpb) ? pref : idb;
    logic [2:0] ec = abort ? 3'b011 : exp_code(pref, idb, cpb);
    @(negedge clk); start = 1'b1; pref_dir = pref;
    @(negedge clk); start = 1'b0; pref_dir = $urandom_range(0, 1);
    for (int s = 0; s <= last; s++) begin
      int w = 0;
      int hold = $urandom_range(0, 3);
      int gap = $urandom_range(0, 3);
      logic [DW-1:0] d = DW'($urandom);
      while (!req_valid && w < 20) begin @(negedge clk); w++; end
      chk(req_valid, "R1 request raised", req_valid, 1);
      chk(req_wr == (s == 2), "R1 request kind", req_wr, (s == 2));
      if (s == 2) chk(req_bit == wbit, "R3/R4 written direction", req_bit, wbit);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(req_valid && req_wr == (s == 2), "R9 request held", req_valid, 1);
      end
      req_ready = 1'b1;
      @(negedge clk); req_ready = 1'b0;
      for (int g = 0; g < gap; g++) begin
        if (poke) start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!req_valid && !done, "R8 no request while waiting", req_valid, 0);
      end
      d[0] = (s == 0) ? idb : cpb;
      cpl_data = d;
      if (s == tmo_at) begin cpl_tmo = 1'b1; cpl_valid = both; end
      else cpl_valid = 1'b1;
      @(negedge clk); cpl_valid = 1'b0; cpl_tmo = 1'b0;
      if (s < last) chk(!done, "R7 no early done", done, 0);
    end
    chk(done, abort ? "R6 done on abort" : "R7 done pulse", done, 1);
    chk(result == ec, abort ? "R6 abort code" : (nodev ? "R2 no-device code" :
        ((idb == cpb) ? "R3 code" : "R4 code")), result, ec);
    chk(err == abort, "R6 error flag", err, abort);
    chk(!busy, "R7 busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    chk(!req_valid, "R2/R6/R8 no further request", req_valid, 0);
    chk(result == ec, "R7 result holds", result, ec);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !err && !req_valid && result == 3'b000,
        "R10 reset state", {busy, done, err, req_valid, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: stray completion and timeout while idle
    cpl_valid = 1'b1; cpl_data = 8'hFF;
    @(negedge clk); cpl_valid = 1'b0; cpl_tmo = 1'b1;
    @(negedge clk); cpl_tmo = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !req_valid, "R9 idle completion ignored", done, 0);
    // directed branch cases
    step(1'b0, 1'b0, 1'b0, 3, 1'b0, 1'b0); // R3 dir 0
    step(1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b0); // R3 dir 1
    step(1'b0, 1'b1, 1'b0, 3, 1'b0, 1'b0); // R4 -> 5
    step(1'b1, 1'b0, 1'b1, 3, 1'b0, 1'b0); // R4 -> 2
    step(1'b1, 1'b1, 1'b1, 3, 1'b0, 1'b0); // R2
    // R6 timeouts at each phase, alone and coincident
    for (int t = 0; t < 3; t++) begin
      step(1'b1, 1'b0, 1'b0, t, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0, t, 1'b1, 1'b0);
    end
    // R6 error cleared by a good step, R8 starts while busy
    step(1'b1, 1'b0, 1'b0, 3, 1'b0, 1'b1);
    // R5 and mixed: random steps with random upper data bits
    for (int i = 0; i < 60; i++) begin
      int tm = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : 3;
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), tm, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule